// File: doc/BRIEF.md
# Real-Time Clock Update Cycle and Status Flags

This block keeps the once-per-second update sequence of a PC-style real-time clock, together with its status flags and its interrupt line. A free-running tick enable, normally 1 MHz, drives a second-phase counter. During the last few ticks of every second the block reports update-in-progress. When the counter wraps at the second boundary, the update ends: the update-ended flag is set and update-in-progress drops.

Software sees three 8-bit registers through a selector. Register A holds the divider and rate bits plus the read-only update-in-progress bit. Register B holds the inhibit bit and the interrupt enables. Register C holds the event flags and the summary interrupt flag. Reading register C empties it and releases the interrupt. Periodic and alarm events come from outside as single-cycle pulses. The block only records them and raises the interrupt when they are enabled.

Top module: `rtc_update_flags`

## Requirements
- R1: `uip` and register A bit 7 are 1 exactly when register B bit 7 (inhibit) is 0 and the phase counter is in its last `UIP_WINDOW` counts (phase >= `TICKS_PER_SEC - UIP_WINDOW`). The phase counter starts at 0 and advances by one on each `tick`.
- R2: A `tick` at phase `TICKS_PER_SEC-1` wraps the phase to 0. If inhibit is 0, the same edge also sets UF (register C bit 4) and ends update-in-progress.
- R3: When UIE (register B bit 4) is 1 at the edge where UF is set, IRQF (register C bit 7) is also set and `irq` goes high.
- R4: While inhibit is 1, update-in-progress stays 0 and a wrap does not set UF.
- R5: While `rd_en` is high with `rd_sel`=2, `rd_data` shows register C as it is. At the next edge register C becomes 0 and `irq` falls. Any event pulse arriving at that same edge is recorded after the clear.
- R6: A write to register A (`wr_sel`=0) stores bits 6:0. The bit 7 read back still follows R1, whatever the written value.
- R7: A `periodic_evt` pulse sets PF (register C bit 6). If PIE (register B bit 6) is 1, it also sets IRQF and raises `irq`.
- R8: When inhibit is cleared while the phase is already inside the window, update-in-progress reads 1 in the very next cycle, and the update ends at the coming wrap.
- R9: An `alarm_evt` pulse sets AF (register C bit 5). If AIE (register B bit 5) is 1, it also sets IRQF and raises `irq`.
- R10: After reset, registers A, B and C read 0 (PIE, AIE, SQWE and all flags cleared), `irq` is 0 and the phase is 0.
- R11: Writes with `wr_sel`=2 have no effect on register C. Register B (`wr_sel`=1) is stored as written. Reads with `rd_sel`=3 return 0.
- R12: `irq` always equals IRQF. IRQF stays set until register C is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Phase advance enable (one per microsecond in normal use) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 = A, 1 = B, 2 = C |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (a read of C clears it) |
| rd_sel | input | 2 | Read source: 0 = A, 1 = B, 2 = C, 3 = none |
| rd_data | output | 8 | Read data for the selected register |
| periodic_evt | input | 1 | Single-cycle periodic event pulse |
| alarm_evt | input | 1 | Single-cycle alarm event pulse |
| uip | output | 1 | Update-in-progress indication |
| irq | output | 1 | Active-high interrupt request |

## Verification
The stimulus is random, from a fixed seed. Tick gaps, sparse writes to B that toggle the inhibit bit and the enables, register C reads that land on the same cycle as event pulses, and writes aimed at the read-only places are all mixed in. This separates a design that drops a same-edge event, or lets a write reach UIP or register C, from one that keeps them. Directed cases fix the ordering around the window. One case raises inhibit inside the window, which must silence the update. Another clears inhibit inside the window, which must bring UIP back at once. Others are the wrap with UIE on and off, and the reset values. Together these tell a window that is off by one, or an update that ignores inhibit, from a correct one.

// File: rtl/rtc_flags_pkg.sv
package rtc_flags_pkg;
   typedef enum logic [1:0] {
      SEL_A    = 2'd0,
      SEL_B    = 2'd1,
      SEL_C    = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int A_UIP  = 7;
   localparam int B_SET  = 7;
   localparam int B_PIE  = 6;
   localparam int B_AIE  = 5;
   localparam int B_UIE  = 4;
   localparam int B_SQWE = 3;
   localparam int C_IRQF = 7;
   localparam int C_PF   = 6;
   localparam int C_AF   = 5;
   localparam int C_UF   = 4;
endpackage

// File: rtl/rtc_second_phase.sv
module rtc_second_phase #(
   parameter int TICKS_PER_SEC = 1000000,
   parameter int UIP_WINDOW    = 244
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic in_window,
   output logic wrap
);
   localparam int PW          = $clog2(TICKS_PER_SEC);
   localparam int WIN_START_I = TICKS_PER_SEC - UIP_WINDOW;
   localparam logic [PW-1:0] LAST      = PW'(TICKS_PER_SEC - 1);
   localparam logic [PW-1:0] WIN_START = PW'(WIN_START_I);

   generate
      if (UIP_WINDOW < 1 || UIP_WINDOW >= TICKS_PER_SEC) begin : g_bad_window
         $error("UIP_WINDOW must lie in 1..TICKS_PER_SEC-1");
      end
      if (TICKS_PER_SEC < 2) begin : g_bad_tps
         $error("TICKS_PER_SEC must be at least 2");
      end
   endgenerate

   logic [PW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (tick) begin
         phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
   end

   assign in_window = (phase_q >= WIN_START);
   assign wrap      = tick && (phase_q == LAST);

   assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= LAST);

   assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (phase_q == '0));
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic in_window,
   input  logic wrap,
   input  logic inhibit,
   output logic uip,
   output logic update_end
);
   assign uip        = in_window && !inhibit;
   assign update_end = wrap && !inhibit;

   assert_end_inside_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      update_end |-> uip);

   assert_no_end_inhibited_R4: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |-> !update_end);
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags
   import rtc_flags_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_clear,
   input  logic       ev_update,
   input  logic       ev_periodic,
   input  logic       ev_alarm,
   input  logic       en_uie,
   input  logic       en_pie,
   input  logic       en_aie,
   output logic [7:0] flags,
   output logic       irq
);
   logic uf_q, pf_q, af_q, irqf_q;
   logic irq_cause;

   assign irq_cause = (ev_update && en_uie) || (ev_periodic && en_pie) ||
                      (ev_alarm && en_aie);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uf_q   <= 1'b0;
         pf_q   <= 1'b0;
         af_q   <= 1'b0;
         irqf_q <= 1'b0;
      end else begin
         uf_q   <= (uf_q   && !rd_clear) || ev_update;
         pf_q   <= (pf_q   && !rd_clear) || ev_periodic;
         af_q   <= (af_q   && !rd_clear) || ev_alarm;
         irqf_q <= (irqf_q && !rd_clear) || irq_cause;
      end
   end

   always_comb begin
      flags         = 8'h00;
      flags[C_IRQF] = irqf_q;
      flags[C_PF]   = pf_q;
      flags[C_AF]   = af_q;
      flags[C_UF]   = uf_q;
   end

   assign irq = irqf_q;

   assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear && !ev_update && !ev_periodic && !ev_alarm) |=> (flags == 8'h00));

   assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(rd_clear));

   assert_periodic_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_periodic && en_pie) |=> irq);
endmodule

// File: rtl/rtc_update_flags.sv
module rtc_update_flags
   import rtc_flags_pkg::*;
#(
   parameter int TICKS_PER_SEC = 1000000,
   parameter int UIP_WINDOW    = 244
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       wr_en,
   input  logic [1:0] wr_sel,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   input  logic [1:0] rd_sel,
   output logic [7:0] rd_data,
   input  logic       periodic_evt,
   input  logic       alarm_evt,
   output logic       uip,
   output logic       irq
);
   logic       in_window, wrap, update_end, rd_clear;
   logic [6:0] reg_a_q;
   logic [7:0] reg_b_q;
   logic [7:0] flags;

   rtc_second_phase #(
      .TICKS_PER_SEC(TICKS_PER_SEC),
      .UIP_WINDOW   (UIP_WINDOW)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .in_window(in_window),
      .wrap     (wrap)
   );

   rtc_update_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_window (in_window),
      .wrap      (wrap),
      .inhibit   (reg_b_q[B_SET]),
      .uip       (uip),
      .update_end(update_end)
   );

   assign rd_clear = rd_en && (rd_sel == SEL_C);

   rtc_status_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_clear   (rd_clear),
      .ev_update  (update_end),
      .ev_periodic(periodic_evt),
      .ev_alarm   (alarm_evt),
      .en_uie     (reg_b_q[B_UIE]),
      .en_pie     (reg_b_q[B_PIE]),
      .en_aie     (reg_b_q[B_AIE]),
      .flags      (flags),
      .irq        (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_a_q <= '0;
         reg_b_q <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_A) reg_a_q <= wr_data[6:0];
         if (wr_sel == SEL_B) reg_b_q <= wr_data;
      end
   end

   always_comb begin
      case (rd_sel)
         SEL_A:   rd_data = {uip, reg_a_q};
         SEL_B:   rd_data = reg_b_q;
         SEL_C:   rd_data = flags;
         default: rd_data = 8'h00;
      endcase
   end

   assert_uf_after_uip_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flags[C_UF]) && !$past(rd_clear)) |-> $past(uip));

   assert_uf_needs_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[C_UF]) |-> !$past(reg_b_q[B_SET]));

   assert_write_a_keeps_uip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_A && !tick && !(wr_en && wr_sel == SEL_B)) |=> $stable(uip));
endmodule

// File: tb/rtc_update_flags_tb.sv
module rtc_update_flags_tb;
   localparam int TPS = 200;
   localparam int WIN = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] wr_sel = 2'd0, rd_sel = 2'd3;
   logic [7:0] wr_data = 8'h00;
   logic       periodic_evt = 1'b0, alarm_evt = 1'b0;
   logic [7:0] rd_data;
   logic       uip, irq;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   int         m_ph;
   logic [6:0] m_a;
   logic [7:0] m_b, m_c;

   always #2.5 clk = ~clk;

   rtc_update_flags #(.TICKS_PER_SEC(TPS), .UIP_WINDOW(WIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
      .periodic_evt(periodic_evt), .alarm_evt(alarm_evt), .uip(uip), .irq(irq)
   );

   function automatic logic exp_uip();
      return !m_b[7] && (m_ph >= TPS - WIN);
   endfunction

   function automatic logic [7:0] exp_read(input logic [1:0] sel);
      case (sel)
         2'd0:    return {exp_uip(), m_a};
         2'd1:    return m_b;
         2'd2:    return m_c;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_ph = 0; m_a = '0; m_b = '0; m_c = '0;
   endtask

   // one cycle: check state outputs, drive, check read path, advance model
   task automatic step(input logic t, input logic we, input logic [1:0] ws,
                       input logic [7:0] wd, input logic re, input logic [1:0] rs,
                       input logic pe, input logic ae);
      logic upd, cause;
      logic [7:0] nc;
      @(negedge clk);
      check("R1 uip", {7'd0, uip}, {7'd0, exp_uip()});
      check("R12 irq", {7'd0, irq}, {7'd0, m_c[7]});
      tick = t; wr_en = we; wr_sel = ws; wr_data = wd;
      rd_en = re; rd_sel = rs; periodic_evt = pe; alarm_evt = ae;
      #1;
      if (re) begin
         case (rs)
            2'd0:    check("R6 read A", rd_data, exp_read(rs));
            2'd1:    check("R11 read B", rd_data, exp_read(rs));
            2'd2:    check("R5 read C", rd_data, exp_read(rs));
            default: check("R11 read none", rd_data, exp_read(rs));
         endcase
      end
      upd   = t && (m_ph == TPS - 1) && !m_b[7];
      cause = (upd && m_b[4]) || (pe && m_b[6]) || (ae && m_b[5]);
      nc = (re && rs == 2'd2) ? 8'h00 : m_c;
      if (upd)   nc[4] = 1'b1;
      if (pe)    nc[6] = 1'b1;
      if (ae)    nc[5] = 1'b1;
      if (cause) nc[7] = 1'b1;
      m_c = nc;
      if (t) m_ph = (m_ph == TPS - 1) ? 0 : m_ph + 1;
      if (we && ws == 2'd0) m_a = wd[6:0];
      if (we && ws == 2'd1) m_b = wd;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 3, 0, 0);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1d2c3b4a));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset values
      step(0, 0, 0, 0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 1, 1, 0, 0);
      step(0, 0, 0, 0, 1, 2, 0, 0);
      // R11: write to C ignored, R6: write A with bit7 set
      step(0, 1, 2, 8'hF0, 1, 2, 0, 0);
      step(0, 1, 0, 8'hA6, 1, 2, 0, 0);
      step(0, 0, 0, 0, 1, 0, 0, 0);
      // R3: enable UIE, run through a wrap
      step(0, 1, 1, 8'h10, 0, 3, 0, 0);
      idle(TPS + 2);
      step(0, 0, 0, 0, 1, 2, 0, 0);   // R5: read clears
      step(0, 0, 0, 0, 1, 2, 0, 0);
      // R4 / R8: raise inhibit inside window, clear it again
      idle(TPS - WIN + 2);
      step(1, 1, 1, 8'h90, 0, 3, 0, 0);
      idle(3);
      step(0, 0, 0, 0, 1, 0, 0, 0);
      step(0, 1, 1, 8'h10, 0, 3, 0, 0);
      step(0, 0, 0, 0, 1, 0, 0, 0);
      idle(WIN);
      step(0, 0, 0, 0, 1, 2, 0, 0);
      // R4: wrap while inhibited sets no UF
      step(0, 1, 1, 8'hF0, 0, 3, 0, 0);
      idle(TPS + 1);
      step(0, 0, 0, 0, 1, 2, 0, 0);
      // R7 / R9: events with and without enables, R5 same-edge event
      step(0, 1, 1, 8'h00, 0, 3, 1, 0);
      step(0, 0, 0, 0, 0, 3, 0, 1);
      step(0, 0, 0, 0, 1, 2, 1, 0);
      step(0, 1, 1, 8'h60, 1, 2, 0, 0);
      step(0, 0, 0, 0, 0, 3, 0, 1);
      step(0, 0, 0, 0, 1, 2, 1, 0);
      step(0, 0, 0, 0, 1, 2, 0, 0);
      // random mix
      for (int k = 0; k < 20000; k++) begin
         logic t, we, re, pe, ae;
         logic [1:0] ws, rs;
         logic [7:0] wd;
         t  = ($urandom % 8) != 0;
         we = ($urandom % 24) == 0;
         ws = 2'($urandom % 4);
         wd = 8'($urandom);
         if (ws == 2'd1 && ($urandom % 4) != 0) wd[7] = 1'b0;
         re = ($urandom % 12) == 0;
         rs = 2'($urandom % 4);
         pe = ($urandom % 40) == 0;
         ae = ($urandom % 50) == 0;
         step(t, we, ws, wd, re, rs, pe, ae);
      end
      step(0, 0, 0, 0, 0, 3, 0, 0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule